// File: doc/BRIEF.md
# SDRAM Refresh and Low-Power Sequencer

This block sits beside an SDRAM access controller. It decides when refresh and low-power commands go to the memory. An interval timer marks each point at which a refresh falls due. Due refreshes are kept in a small saturating debt counter and issued as auto-refresh commands, each spaced by the row-cycle time. If the access controller reports an open bank, and the sequencer has not already closed all banks since the last grant, the sequencer first issues a precharge-all and waits the precharge time.

The sequencer also places the device in power-down or self refresh through the clock-enable pin when the system asks for it. It keeps the required row-cycle gap after leaving self refresh. It cuts power-down short as soon as a refresh falls due, so the device is never left idle past its refresh interval. A grant output tells the access arbiter when it may start an access. The command it may then issue goes out on the cycle after the grant, which is the same pipeline stage as the sequencer's own registered command pins. All timing values are counts of clock cycles set by parameters.

Top module: `sdram_pwr_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, the pins carry a no-operation (RAS_n, CAS_n and WE_n all 1), CKE is 1, the A10 pin is 0, and grant and busy are 0.
- R2: When no access is in progress, an auto refresh (RAS_n 0, CAS_n 0, WE_n 1, CKE 1, A10 0) appears every T_REFI cycles.
- R3: After an auto refresh on the pins in cycle c, the first grant to a waiting access is in cycle c+T_RC-1, so that the access command lands T_RC cycles after the refresh.
- R4: A grant already held stays high while acc_req stays high, even after a refresh falls due. Busy is 1 while a refresh is owed. No new grant is given while refreshes are owed.
- R5: Up to MAX_DEBT due refreshes are owed at once, and further due points are dropped. When the grant is released, the owed refreshes go out back to back, exactly T_RC cycles apart.
- R6: If a refresh falls due while bank_open is 1 and no precharge-all has been issued since the last grant, a precharge-all (RAS_n 0, CAS_n 1, WE_n 0, A10 1) goes out first. The auto refresh then follows exactly T_RP cycles later. bank_open is then ignored until the next grant.
- R7: Power-down drops CKE with a no-operation. CKE falls T_RC cycles after a refresh, or T_RP cycles after the sequencer's own precharge-all. CKE rises in the cycle after pd_req is seen low.
- R8: A refresh falling due during power-down raises CKE T_REFI cycles after the previous refresh, and the auto refresh follows one cycle later.
- R9: A self-refresh request issues RAS_n 0, CAS_n 0, WE_n 1 with CKE 0 in the cycle after the request is taken. CKE then stays 0 with no command for as long as the request is held.
- R10: After self refresh ends, CKE rises one cycle after the request drops, and the first grant comes T_RC-1 cycles after that rise.
- R11: The interval timer is held in self refresh and restarts at exit, so the first auto refresh comes T_REFI+1 cycles after CKE rises.
- R12: When the sequencer is idle, a pending refresh comes before an access request, an access request comes before a low-power request, and self refresh comes before power-down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Access arbiter wants, or keeps, the command pins |
| bank_open | input | 1 | At least one bank has a row open |
| pd_req | input | 1 | Request to enter and stay in power-down |
| sr_req | input | 1 | Request to enter and stay in self refresh |
| acc_gnt | output | 1 | Access may proceed; its command goes out on the next cycle |
| busy | output | 1 | Refresh owed or sequencer occupied |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_cke | output | 1 | Clock enable |
| sd_a10 | output | 1 | Address bit 10; high selects all banks for precharge |

## Verification
Two events can fall in the same cycle: an interval expiry, which adds to the debt, and the issue of a refresh, which removes from it. If the debt is already full, the expiry must still count, because one slot frees up in that same cycle. The bench provokes this by holding a grant across five expiries so the debt saturates, then releasing it so the burst starts. It judges the result by the number of refreshes that come back to back and by the cycle of the next interval refresh. A second collision is power-down meeting a due refresh: the bench checks the exact cycles at which CKE rises and the refresh follows.

// File: rtl/srps_pkg.sv
`timescale 1ns/1ps
package srps_pkg;

    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
        logic cke;
        logic a10;
    } srps_pins_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ACC,
        SQ_WAIT,
        SQ_PD,
        SQ_SR
    } srps_state_e;

    function automatic srps_pins_t pins_nop(input logic cke);
        srps_pins_t p;
        p.ras_n = 1'b1;
        p.cas_n = 1'b1;
        p.we_n  = 1'b1;
        p.cke   = cke;
        p.a10   = 1'b0;
        return p;
    endfunction

    // Refresh command; CKE low turns it into self-refresh entry.
    function automatic srps_pins_t pins_ref(input logic cke);
        srps_pins_t p;
        p.ras_n = 1'b0;
        p.cas_n = 1'b0;
        p.we_n  = 1'b1;
        p.cke   = cke;
        p.a10   = 1'b0;
        return p;
    endfunction

    function automatic srps_pins_t pins_prea();
        srps_pins_t p;
        p.ras_n = 1'b0;
        p.cas_n = 1'b1;
        p.we_n  = 1'b0;
        p.cke   = 1'b1;
        p.a10   = 1'b1;
        return p;
    endfunction

endpackage

// File: rtl/srps_wait_ctr.sv
`timescale 1ns/1ps
module srps_wait_ctr #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);
    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } wc_reg_t;

    wc_reg_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.cnt = load_val;
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done = (q.cnt == '0);

    // The sequencer only starts a new gap once the previous one has run out.
    assert_reload_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (q.cnt == '0));

endmodule

// File: rtl/srps_ref_timer.sv
`timescale 1ns/1ps
module srps_ref_timer #(
    parameter int T_REFI   = 780,
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic consume,
    output logic pending
);
    localparam int CW = (T_REFI > 2) ? $clog2(T_REFI) : 1;
    localparam int DW = $clog2(MAX_DEBT + 1);
    localparam logic [CW-1:0] LAST = CW'(T_REFI - 1);
    localparam logic [DW-1:0] FULL = DW'(MAX_DEBT);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [DW-1:0] debt;
    } tm_reg_t;

    tm_reg_t q, d;
    logic    tick;
    logic    add;

    always_comb begin
        d    = q;
        tick = !hold && (q.cnt == LAST);
        // A full debt still accepts a new due point if one leaves this cycle.
        add  = tick && ((q.debt != FULL) || consume);
        if (hold) begin
            d.cnt  = '0;
            d.debt = '0;
        end else begin
            d.cnt  = tick ? '0 : q.cnt + 1'b1;
            d.debt = q.debt - DW'(consume) + DW'(add);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = (q.debt != '0);

    assert_debt_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        q.debt <= FULL);

    assert_consume_owed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        consume |-> (q.debt != '0));

    assert_hold_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hold) |-> (q.debt == '0));

endmodule

// File: rtl/srps_fsm.sv
`timescale 1ns/1ps
module srps_fsm
    import srps_pkg::*;
#(
    parameter int T_RC = 7,
    parameter int T_RP = 3,
    parameter int WW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_req,
    input  logic          bank_open,
    input  logic          pd_req,
    input  logic          sr_req,
    input  logic          pending,
    input  logic          wait_done,
    output logic          consume,
    output logic          in_sr,
    output logic          wload,
    output logic [WW-1:0] wval,
    output logic          acc_gnt,
    output logic          busy,
    output srps_pins_t    pins
);
    // Gap counter reload values: the counter and the return to idle add two cycles.
    localparam logic [WW-1:0] LD_RC = WW'(T_RC - 2);
    localparam logic [WW-1:0] LD_RP = WW'(T_RP - 2);

    typedef struct packed {
        srps_state_e state;
        srps_pins_t  pins;
        logic        pa;
    } fsm_reg_t;

    fsm_reg_t q, d;
    logic     open_eff;

    assign open_eff = bank_open && !q.pa;

    always_comb begin
        d       = q;
        d.pins  = pins_nop(q.pins.cke);
        consume = 1'b0;
        wload   = 1'b0;
        wval    = '0;
        case (q.state)
            SQ_IDLE: begin
                if (pending) begin
                    wload   = 1'b1;
                    d.state = SQ_WAIT;
                    if (open_eff) begin
                        d.pins = pins_prea();
                        d.pa   = 1'b1;
                        wval   = LD_RP;
                    end else begin
                        d.pins  = pins_ref(1'b1);
                        consume = 1'b1;
                        wval    = LD_RC;
                    end
                end else if (acc_req) begin
                    d.state = SQ_ACC;
                    d.pa    = 1'b0;
                end else if (sr_req || pd_req) begin
                    if (open_eff) begin
                        d.pins  = pins_prea();
                        d.pa    = 1'b1;
                        wload   = 1'b1;
                        wval    = LD_RP;
                        d.state = SQ_WAIT;
                    end else if (sr_req) begin
                        d.pins  = pins_ref(1'b0);
                        d.state = SQ_SR;
                    end else begin
                        d.pins.cke = 1'b0;
                        d.state    = SQ_PD;
                    end
                end
            end
            SQ_ACC: begin
                if (!acc_req) d.state = SQ_IDLE;
            end
            SQ_WAIT: begin
                if (wait_done) d.state = SQ_IDLE;
            end
            SQ_PD: begin
                if (pending || !pd_req) begin
                    d.pins.cke = 1'b1;
                    d.state    = SQ_IDLE;
                end
            end
            SQ_SR: begin
                if (!sr_req) begin
                    d.pins.cke = 1'b1;
                    wload      = 1'b1;
                    wval       = LD_RC;
                    d.state    = SQ_WAIT;
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.state <= SQ_IDLE;
            q.pins  <= pins_nop(1'b1);
            q.pa    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pins    = q.pins;
    assign in_sr   = (q.state == SQ_SR);
    assign acc_gnt = acc_req && ((q.state == SQ_ACC) || ((q.state == SQ_IDLE) && !pending));
    assign busy    = pending || !((q.state == SQ_IDLE) || (q.state == SQ_ACC));

    assert_ref_with_cke_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pins.ras_n && !q.pins.cas_n && q.pins.we_n && q.pins.cke) |-> $past(q.pins.cke));

    assert_no_gnt_on_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pins.ras_n && !q.pins.cas_n && q.pins.cke) |-> !acc_gnt);

    assert_prea_all_banks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pins.ras_n && q.pins.cas_n && !q.pins.we_n) |-> q.pins.a10);

    assert_quiet_while_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pins.cke && !$past(q.pins.cke)) |-> (q.pins.ras_n && q.pins.cas_n && q.pins.we_n));

    assert_sref_enters_sr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!q.pins.ras_n && !q.pins.cas_n && !q.pins.cke) |-> in_sr);

    assert_no_gnt_when_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !q.pins.cke |-> !acc_gnt);

endmodule

// File: rtl/sdram_pwr_seq.sv
`timescale 1ns/1ps
module sdram_pwr_seq
    import srps_pkg::*;
#(
    parameter int T_REFI   = 780,
    parameter int T_RC     = 7,
    parameter int T_RP     = 3,
    parameter int MAX_DEBT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic acc_req,
    input  logic bank_open,
    input  logic pd_req,
    input  logic sr_req,
    output logic acc_gnt,
    output logic busy,
    output logic sd_ras_n,
    output logic sd_cas_n,
    output logic sd_we_n,
    output logic sd_cke,
    output logic sd_a10
);
    localparam int WMAX = (T_RC > T_RP) ? T_RC : T_RP;
    localparam int WW   = (WMAX > 2) ? $clog2(WMAX) : 1;

    logic          pending;
    logic          consume;
    logic          in_sr;
    logic          wload;
    logic [WW-1:0] wval;
    logic          wait_done;
    srps_pins_t    pins;

    srps_ref_timer #(
        .T_REFI   (T_REFI),
        .MAX_DEBT (MAX_DEBT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold    (in_sr),
        .consume (consume),
        .pending (pending)
    );

    srps_wait_ctr #(
        .WIDTH (WW)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wload),
        .load_val (wval),
        .done     (wait_done)
    );

    srps_fsm #(
        .T_RC (T_RC),
        .T_RP (T_RP),
        .WW   (WW)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_req   (acc_req),
        .bank_open (bank_open),
        .pd_req    (pd_req),
        .sr_req    (sr_req),
        .pending   (pending),
        .wait_done (wait_done),
        .consume   (consume),
        .in_sr     (in_sr),
        .wload     (wload),
        .wval      (wval),
        .acc_gnt   (acc_gnt),
        .busy      (busy),
        .pins      (pins)
    );

    assign sd_ras_n = pins.ras_n;
    assign sd_cas_n = pins.cas_n;
    assign sd_we_n  = pins.we_n;
    assign sd_cke   = pins.cke;
    assign sd_a10   = pins.a10;

endmodule

// File: tb/tb_sdram_pwr_seq.sv
`timescale 1ns/1ps
module tb_sdram_pwr_seq;
    localparam int T_REFI = 100;
    localparam int T_RC   = 5;
    localparam int T_RP   = 3;
    localparam int MAXD   = 3;

    localparam int EV_REF  = 0;
    localparam int EV_PREA = 1;
    localparam int EV_SREF = 2;
    localparam int EV_HIGH = 3;
    localparam int EV_LOW  = 4;
    localparam int EV_GNT  = 5;
    localparam int EV_ANY  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_req = 1'b0, bank_open = 1'b0, pd_req = 1'b0, sr_req = 1'b0;
    logic acc_gnt, busy, sd_ras_n, sd_cas_n, sd_we_n, sd_cke, sd_a10;

    int cyc = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    sdram_pwr_seq #(
        .T_REFI (T_REFI), .T_RC (T_RC), .T_RP (T_RP), .MAX_DEBT (MAXD)
    ) dut (
        .clk (clk), .rst_n (rst_n), .acc_req (acc_req), .bank_open (bank_open),
        .pd_req (pd_req), .sr_req (sr_req), .acc_gnt (acc_gnt), .busy (busy),
        .sd_ras_n (sd_ras_n), .sd_cas_n (sd_cas_n), .sd_we_n (sd_we_n),
        .sd_cke (sd_cke), .sd_a10 (sd_a10)
    );

    function automatic bit is_ref();
        return !sd_ras_n && !sd_cas_n && sd_we_n && sd_cke;
    endfunction
    function automatic bit is_prea();
        return !sd_ras_n && sd_cas_n && !sd_we_n;
    endfunction
    function automatic bit is_sref();
        return !sd_ras_n && !sd_cas_n && sd_we_n && !sd_cke;
    endfunction
    function automatic bit is_nop();
        return sd_ras_n && sd_cas_n && sd_we_n;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    task automatic step_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic wait_ev(input int kind, output int c);
        bit hit;
        c = -1;
        for (int n = 0; n < 2000; n++) begin
            @(negedge clk);
            case (kind)
                EV_REF:  hit = is_ref();
                EV_PREA: hit = is_prea();
                EV_SREF: hit = is_sref();
                EV_HIGH: hit = sd_cke;
                EV_LOW:  hit = !sd_cke;
                EV_GNT:  hit = acc_gnt;
                default: hit = is_ref() || is_prea();
            endcase
            if (hit) begin
                c = cyc;
                return;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        summary();
        $finish;
    end

    initial begin
        int a1, a2, g, r, b1, b2, b3, b4, p, s, e, f, u, v, z, bad;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 nop in reset", int'(is_nop()), 1);
        chk("R1 cke in reset", int'(sd_cke), 1);
        chk("R1 a10 in reset", int'(sd_a10), 0);
        chk("R1 gnt/busy in reset", int'(acc_gnt) + int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", int'(is_nop() && sd_cke && !busy), 1);

        // R2: periodic refresh
        wait_ev(EV_REF, a1);
        wait_ev(EV_REF, a2);
        chk("R2 interval", a2 - a1, T_REFI);
        chk("R2 a10 low on refresh", int'(sd_a10), 0);

        // R3: access waits T_RC after refresh
        acc_req = 1'b1;
        wait_ev(EV_GNT, g);
        chk("R3 first grant", g, a2 + T_RC - 1);

        // R4: held grant survives a due refresh
        step_to(a2 + T_REFI + 3);
        chk("R4 grant held", int'(acc_gnt), 1);
        chk("R4 busy while owed", int'(busy), 1);
        chk("R4 no refresh during grant", int'(is_nop()), 1);

        // R5: five due points, three kept; release just after the fifth
        r = a2 + 5 * T_REFI + 5;
        step_to(r);
        acc_req = 1'b0;
        wait_ev(EV_REF, b1);
        chk("R5 burst first", b1, r + 2);
        acc_req = 1'b1;
        wait_ev(EV_REF, b2);
        chk("R5 burst second", b2, b1 + T_RC);
        wait_ev(EV_REF, b3);
        chk("R5 burst third", b3, b2 + T_RC);
        wait_ev(EV_GNT, g);
        chk("R4 no new grant while owed", g, b3 + T_RC - 1);
        step_to(g + 1);
        acc_req = 1'b0;
        wait_ev(EV_REF, b4);
        chk("R5 saturation drops extra", b4, a2 + 6 * T_REFI);

        // R6: precharge-all before refresh
        bank_open = 1'b1;
        wait_ev(EV_ANY, p);
        chk("R6 precharge first", int'(is_prea()), 1);
        chk("R6 precharge cycle", p, b4 + T_REFI);
        chk("R6 all banks", int'(sd_a10), 1);
        wait_ev(EV_ANY, b1);
        chk("R6 refresh after tRP", b1, p + T_RP);
        wait_ev(EV_ANY, s);
        chk("R6 open ignored until grant", int'(is_ref()), 1);
        chk("R6 next refresh cycle", s, p + T_REFI);
        bank_open = 1'b0;

        // R7, R8: power-down and its abort
        pd_req = 1'b1;
        wait_ev(EV_LOW, f);
        chk("R7 entry after tRC", f, s + T_RC);
        wait_ev(EV_HIGH, e);
        chk("R8 abort on due refresh", e, s + T_REFI);
        wait_ev(EV_REF, b1);
        chk("R8 refresh follows", b1, e + 1);
        wait_ev(EV_LOW, f);
        chk("R7 re-entry", f, b1 + T_RC);
        step_to(s + 120);
        pd_req = 1'b0;
        wait_ev(EV_HIGH, e);
        chk("R7 exit latency", e, s + 121);

        // R7: own precharge then power-down after tRP
        step_to(s + 125);
        acc_req = 1'b1;
        @(negedge clk);
        acc_req = 1'b0;
        bank_open = 1'b1;
        pd_req = 1'b1;
        wait_ev(EV_PREA, p);
        wait_ev(EV_LOW, f);
        chk("R7 entry after tRP", f, p + T_RP);
        step_to(f + 3);
        pd_req = 1'b0;
        bank_open = 1'b0;
        wait_ev(EV_HIGH, e);

        // R9: self refresh
        u = e + 4;
        step_to(u);
        sr_req = 1'b1;
        wait_ev(EV_SREF, b1);
        chk("R9 entry cycle", b1, u + 1);
        bad = 0;
        for (int i = 0; i < 3 * T_REFI; i++) begin
            @(negedge clk);
            if (sd_cke || !is_nop()) bad++;
        end
        chk("R9 quiet while held", bad, 0);

        // R10, R11: exit
        v = cyc;
        sr_req = 1'b0;
        acc_req = 1'b1;
        wait_ev(EV_HIGH, e);
        chk("R10 cke rise", e, v + 1);
        wait_ev(EV_GNT, g);
        chk("R10 grant after exit", g, e + T_RC - 1);
        @(negedge clk);
        acc_req = 1'b0;
        wait_ev(EV_REF, z);
        chk("R11 timer restart", z, e + T_REFI + 1);

        // R12: self refresh wins over power-down
        sr_req = 1'b1;
        pd_req = 1'b1;
        wait_ev(EV_LOW, f);
        chk("R12 sref chosen", int'(is_sref()), 1);
        chk("R12 entry cycle", f, z + T_RC);
        step_to(f + 5);
        sr_req = 1'b0;
        pd_req = 1'b0;
        wait_ev(EV_HIGH, e);
        chk("R12 exit", e, f + 6);

        summary();
        $finish;
    end
endmodule